// File: doc/BRIEF.md
# Advertising Packet CRC and Whitening Encoder

This block turns a raw advertising packet into the byte stream a radio transmit FIFO expects. The caller writes up to 32 bytes into an internal buffer through a byte-wide load port. The last three of those bytes carry the CRC initial value. The caller then supplies the packet length and a 6-bit channel index and pulses start.

The engine reads the three trailing bytes as the 24-bit CRC seed. It runs the CRC one bit per clock, least significant bit first, over every byte before the seed bytes. It then writes the bit-reversed CRC bytes over the seed positions. Next it whitens every packet byte, CRC included, with an 8-bit register seeded from the channel. Each whitened byte is bit-reversed and written back in place. When the last byte has been stored, done rises and the encoded packet can be read through a registered read port.

A typical beacon is 32 bytes long: a two-byte header, six address bytes, a flags field, a name field carrying 16 message bytes, and the three seed bytes (0x55 each). It is encoded once for each advertising channel, and each pass gives a different whitening result.

Top module: `adv_pkt_encoder`

## Requirements
- R1: While no encode is running, a load write stores ld_data at buffer position ld_addr. Positions at or beyond the effective length are never modified by an encode.
- R2: The effective length is pkt_len, limited to the range 3..32. A pkt_len above 32 encodes 32 bytes, and a pkt_len below 3 encodes 3 bytes.
- R3: The CRC state is seeded as {byte[n-3], byte[n-2], byte[n-1]}, with byte[n-3] as the most significant byte, where n is the effective length. For each data byte 0..n-4, bit 0 first, the 24-bit state shifts left one place. When the bit shifted out differs from the data bit, 0x00065B is XORed into the state.
- R4: After the CRC pass, positions n-3, n-2 and n-1 hold the bit-reversed CRC bytes, most significant byte first. Whitening is then applied to these positions as well.
- R5: The 8-bit whitening register starts at bitrev8(chan_idx) OR 0x02. For every bit of every byte, bit 0 first: if register bit 7 is set, the register is XORed with 0x11 and the data bit is inverted. The register then shifts left by one.
- R6: Each whitened byte is bit-reversed before it is stored as the encoded result.
- R7: done goes low on the clock edge that accepts a start and on any accepted load write. It goes high only when the final encoded byte has been stored, and it is never high while an encode is running.
- R8: When done was high in both of the two preceding cycles, rd_data equals the buffer byte at the rd_addr presented two clock edges earlier. After any cycle in which done is low, rd_data is zero.
- R9: A start pulse that arrives while an encode is running has no effect: the length, channel and result of the running encode are kept.
- R10: A load write that arrives while an encode is running is ignored and does not alter the result.
- R11: After reset, done is low and rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load write enable |
| ld_addr | input | 5 | Load byte position |
| ld_data | input | 8 | Load byte value |
| pkt_len | input | 6 | Requested packet length in bytes (limited to 3..32) |
| chan_idx | input | 6 | Channel index that seeds the whitening register |
| start | input | 1 | Start strobe; accepted only when no encode is running |
| rd_addr | input | 5 | Read byte position |
| rd_data | output | 8 | Encoded byte, two-edge latency; zero unless done is settled |
| done | output | 1 | Encoded packet is available |

## Verification
The bench builds the block with its default parameters: a 32-byte buffer, a 6-bit length port and a 6-bit channel index. The 6-bit length port lets the bench request lengths up to 63, which exercises the upper limit, and lengths 0 to 2, which exercise the lower limit. The full channel range seeds the whitening register with every possible value, including the three advertising channels used for beacons. The 32-byte depth allows full-length beacons as well as random lengths down to three bytes, where no data byte enters the CRC at all.

// File: rtl/aenc_pkg.sv
package aenc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEED,
    ST_C_FETCH,
    ST_C_LOAD,
    ST_C_BITS,
    ST_C_WR,
    ST_W_FETCH,
    ST_W_LOAD,
    ST_W_BITS,
    ST_W_WR
  } enc_state_e;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = b[7-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/aenc_byte_ram.sv
module aenc_byte_ram #(
  parameter int AW = 5,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/aenc_crc_step.sv
module aenc_crc_step #(
  parameter int          W    = 24,
  parameter logic [23:0] TAPS = 24'h00065B
) (
  input  logic [W-1:0] crc_i,
  input  logic         din,
  output logic [W-1:0] crc_o
);

  logic fb;

  always_comb begin
    fb    = crc_i[W-1] ^ din;
    crc_o = {crc_i[W-2:0], 1'b0} ^ (fb ? TAPS[W-1:0] : '0);
  end

endmodule

// File: rtl/aenc_wht_step.sv
module aenc_wht_step #(
  parameter int         W    = 8,
  parameter logic [7:0] TAPS = 8'h11
) (
  input  logic [W-1:0] lfsr_i,
  input  logic         din,
  output logic [W-1:0] lfsr_o,
  output logic         dout
);

  always_comb begin
    dout   = din ^ lfsr_i[W-1];
    lfsr_o = {lfsr_i[W-2:0], 1'b0} ^ (lfsr_i[W-1] ? {TAPS[W-2:0], 1'b0} : '0);
  end

endmodule

// File: rtl/adv_pkt_encoder.sv
module adv_pkt_encoder
  import aenc_pkg::*;
#(
  parameter int          MAX_LEN  = 32,
  parameter int          CH_W     = 6,
  parameter int          CRC_W    = 24,
  parameter logic [23:0] CRC_TAPS = 24'h00065B,
  parameter logic [7:0]  WHT_TAPS = 8'h11,
  localparam int AW        = $clog2(MAX_LEN),
  localparam int LW        = AW + 1,
  localparam int CRC_BYTES = CRC_W / 8,
  localparam int CW        = $clog2(CRC_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data,
  input  logic [LW-1:0] pkt_len,
  input  logic [CH_W-1:0] chan_idx,
  input  logic          start,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          done
);

  enc_state_e state_q;
  logic [LW-1:0]    len_q, len_eff, seed_base;
  logic [AW-1:0]    ptr_q, seed_addr;
  logic [CW-1:0]    cnt_q;
  logic [2:0]       bcnt_q;
  logic [7:0]       sh_q, ob_q, wh_q, wh_nx, wht_seed, crc_byte;
  logic [CRC_W-1:0] crc_q, crc_nx, crc_shifted;
  logic             wbit, done_q, done_d1, busy;
  logic [7:0]       rd_q;
  logic             last_data, last_byte;

  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_q;

  aenc_byte_ram #(.AW(AW), .DW(8)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  aenc_crc_step #(.W(CRC_W), .TAPS(CRC_TAPS)) u_crc (
    .crc_i(crc_q),
    .din  (sh_q[0]),
    .crc_o(crc_nx)
  );

  aenc_wht_step #(.W(8), .TAPS(WHT_TAPS)) u_wht (
    .lfsr_i(wh_q),
    .din   (sh_q[0]),
    .lfsr_o(wh_nx),
    .dout  (wbit)
  );

  // Length limiting and derived positions
  always_comb begin
    if (pkt_len > LW'(MAX_LEN)) begin
      len_eff = LW'(MAX_LEN);
    end else if (pkt_len < LW'(CRC_BYTES)) begin
      len_eff = LW'(CRC_BYTES);
    end else begin
      len_eff = pkt_len;
    end
    wht_seed    = rev8(8'(chan_idx)) | 8'h02;
    seed_base   = len_q - LW'(CRC_BYTES);
    seed_addr   = seed_base[AW-1:0] + AW'(cnt_q);
    crc_shifted = crc_q << (8 * cnt_q);
    crc_byte    = crc_shifted[CRC_W-1 -: 8];
    last_data   = ({1'b0, ptr_q} == len_q - LW'(CRC_BYTES + 1));
    last_byte   = ({1'b0, ptr_q} == len_q - LW'(1));
    busy        = (state_q != ST_IDLE);
  end

  // Buffer port steering
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = ld_addr;
    ram_wdata = ld_data;
    ram_raddr = rd_addr;
    case (state_q)
      ST_IDLE:    ram_we = ld_we && !start;
      ST_SEED:    ram_raddr = seed_addr;
      ST_C_FETCH: ram_raddr = ptr_q;
      ST_W_FETCH: ram_raddr = ptr_q;
      ST_C_WR: begin
        ram_we    = 1'b1;
        ram_waddr = seed_addr;
        ram_wdata = rev8(crc_byte);
      end
      ST_W_WR: begin
        ram_we    = 1'b1;
        ram_waddr = ptr_q;
        ram_wdata = rev8(ob_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      done_d1 <= 1'b0;
      rd_q    <= '0;
      len_q   <= LW'(CRC_BYTES);
      ptr_q   <= '0;
      cnt_q   <= '0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      ob_q    <= '0;
      wh_q    <= '0;
      crc_q   <= '0;
    end else begin
      done_d1 <= done_q;
      rd_q    <= (done_q && done_d1) ? ram_q : '0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            len_q   <= len_eff;
            wh_q    <= wht_seed;
            cnt_q   <= '0;
            ptr_q   <= '0;
            done_q  <= 1'b0;
            state_q <= ST_SEED;
          end else if (ld_we) begin
            done_q <= 1'b0;
          end
        end
        ST_SEED: begin
          if (cnt_q != '0) begin
            crc_q <= {crc_q[CRC_W-9:0], ram_q};
          end
          if (cnt_q == CW'(CRC_BYTES)) begin
            cnt_q   <= '0;
            state_q <= (len_q == LW'(CRC_BYTES)) ? ST_C_WR : ST_C_FETCH;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_C_FETCH: state_q <= ST_C_LOAD;
        ST_C_LOAD: begin
          sh_q    <= ram_q;
          bcnt_q  <= '0;
          state_q <= ST_C_BITS;
        end
        ST_C_BITS: begin
          crc_q  <= crc_nx;
          sh_q   <= sh_q >> 1;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            if (last_data) begin
              cnt_q   <= '0;
              state_q <= ST_C_WR;
            end else begin
              ptr_q   <= ptr_q + AW'(1);
              state_q <= ST_C_FETCH;
            end
          end
        end
        ST_C_WR: begin
          if (cnt_q == CW'(CRC_BYTES - 1)) begin
            cnt_q   <= '0;
            ptr_q   <= '0;
            state_q <= ST_W_FETCH;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_W_FETCH: state_q <= ST_W_LOAD;
        ST_W_LOAD: begin
          sh_q    <= ram_q;
          bcnt_q  <= '0;
          state_q <= ST_W_BITS;
        end
        ST_W_BITS: begin
          wh_q   <= wh_nx;
          ob_q   <= {wbit, ob_q[7:1]};
          sh_q   <= sh_q >> 1;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            state_q <= ST_W_WR;
          end
        end
        ST_W_WR: begin
          if (last_byte) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ptr_q   <= ptr_q + AW'(1);
            state_q <= ST_W_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign done    = done_q;

endmodule

// File: rtl/aenc_checker.sv
module aenc_checker #(
  parameter int LW      = 6,
  parameter int MAX_LEN = 32,
  parameter int MIN_LEN = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          done,
  input logic          busy,
  input logic [7:0]    rd_data,
  input logic [LW-1:0] len_q
);

  AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
    !done |=> (rd_data == 8'h00)); // R8

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> !done); // R7

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(len_q)); // R9

  AST_LEN_LIMITED: assert property (@(posedge clk) disable iff (rst)
    busy |-> (len_q >= LW'(MIN_LEN) && len_q <= LW'(MAX_LEN))); // R2

endmodule

bind adv_pkt_encoder aenc_checker #(
  .LW(LW), .MAX_LEN(MAX_LEN), .MIN_LEN(CRC_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .busy(busy), .rd_data(rd_data), .len_q(len_q)
);

// File: tb/adv_pkt_encoder_tb.sv
module adv_pkt_encoder_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       ld_we;
  logic [4:0] ld_addr;
  logic [7:0] ld_data;
  logic [5:0] pkt_len;
  logic [5:0] chan_idx;
  logic       start;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic       done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  logic [7:0] pkt  [32];
  logic [7:0] expv [32];

  always #5 clk = ~clk;

  adv_pkt_encoder u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .pkt_len(pkt_len), .chan_idx(chan_idx), .start(start),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  function automatic logic [7:0] rv(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  // Reference encoder built from R2..R6
  task automatic model(input int len_in, input logic [5:0] ch);
    int n, dl;
    logic [23:0] crc;
    logic [7:0]  wc, d;
    n = (len_in > 32) ? 32 : ((len_in < 3) ? 3 : len_in);
    dl = n - 3;
    for (int i = 0; i < 32; i++) expv[i] = pkt[i];
    crc = {expv[dl], expv[dl+1], expv[dl+2]};
    for (int i = 0; i < dl; i++) begin
      d = expv[i];
      for (int v = 0; v < 8; v++) begin
        logic t;
        t = crc[23];
        crc = {crc[22:0], 1'b0};
        if (t != d[v]) crc = crc ^ 24'h00065B;
      end
    end
    expv[dl]   = rv(crc[23:16]);
    expv[dl+1] = rv(crc[15:8]);
    expv[dl+2] = rv(crc[7:0]);
    wc = rv({2'b00, ch}) | 8'h02;
    for (int i = 0; i < n; i++) begin
      for (int m = 0; m < 8; m++) begin
        if (wc[7]) begin
          wc = wc ^ 8'h11;
          expv[i][m] = ~expv[i][m];
        end
        wc = {wc[6:0], 1'b0};
      end
      expv[i] = rv(expv[i]);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 5'(i); ld_data = pkt[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic kick(input logic [5:0] len, input logic [5:0] ch);
    @(negedge clk);
    start = 1'b1; pkt_len = len; chan_idx = ch;
    @(negedge clk);
    start = 1'b0;
    check("R7 done low after start", {7'd0, done}, 8'h00);
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check("R7 done reached", {7'd0, done}, 8'h01);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 5'(a);
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic compare_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      check(req, v, expv[i]);
    end
  endtask

  task automatic beacon(input logic [7:0] tag);
    pkt[0] = 8'h42; pkt[1] = 8'h1B;
    for (int i = 2; i < 8; i++) pkt[i] = 8'hC0 + 8'(i);
    pkt[8] = 8'h02; pkt[9] = 8'h01; pkt[10] = 8'h05;
    pkt[11] = 8'd17; pkt[12] = 8'h08;
    for (int i = 13; i < 29; i++) pkt[i] = tag + 8'(i);
    pkt[29] = 8'h55; pkt[30] = 8'h55; pkt[31] = 8'h55;
  endtask

  initial begin
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; ld_we = 0; ld_addr = 0; ld_data = 0; pkt_len = 0;
    chan_idx = 0; start = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset done", {7'd0, done}, 8'h00);
    check("R11 reset rd_data", rd_data, 8'h00);

    // Directed beacons on the three advertising channels (R3 R4 R5 R6)
    for (int c = 37; c <= 39; c++) begin
      beacon(8'(c));
      load_all();
      model(32, 6'(c));
      kick(6'd32, 6'(c));
      wait_done();
      compare_all("R3 R4 R5 R6 beacon");
    end

    // Random packets, lengths and channels
    for (int r = 0; r < 12; r++) begin
      int len;
      logic [5:0] ch;
      for (int i = 0; i < 32; i++) pkt[i] = 8'($urandom);
      len = int'($urandom_range(32, 3));
      ch  = 6'($urandom);
      load_all();
      model(len, ch);
      kick(6'(len), ch);
      wait_done();
      compare_all("R3 R5 R6 random");
    end

    // Length above the limit (R2)
    for (int i = 0; i < 32; i++) pkt[i] = 8'($urandom);
    load_all();
    model(32, 6'd12);
    kick(6'd45, 6'd12);
    wait_done();
    compare_all("R2 length above limit");

    // Length below the limit: only three bytes encoded (R2, R1)
    for (int i = 0; i < 32; i++) pkt[i] = 8'($urandom);
    load_all();
    model(3, 6'd63);
    kick(6'd1, 6'd63);
    wait_done();
    compare_all("R2 R1 length below limit, tail untouched");

    // Start while running is ignored (R9)
    beacon(8'h5A);
    load_all();
    model(32, 6'd38);
    kick(6'd32, 6'd38);
    repeat (20) @(negedge clk);
    start = 1'b1; pkt_len = 6'd7; chan_idx = 6'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    compare_all("R9 start during run");

    // Load write while running is ignored (R10)
    for (int i = 0; i < 32; i++) pkt[i] = 8'($urandom);
    load_all();
    model(20, 6'd5);
    kick(6'd20, 6'd5);
    repeat (30) @(negedge clk);
    ld_we = 1'b1; ld_addr = 5'd25; ld_data = ~pkt[25];
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 5'd2; ld_data = ~pkt[2];
    @(negedge clk);
    ld_we = 1'b0;
    wait_done();
    compare_all("R10 load during run");

    // A load write clears done, and the read port then returns zero (R7 R8)
    @(negedge clk);
    ld_we = 1'b1; ld_addr = 5'd0; ld_data = 8'hA5;
    @(negedge clk);
    ld_we = 1'b0;
    check("R7 done cleared by load", {7'd0, done}, 8'h00);
    rd(0, v);
    check("R8 rd_data zero while not done", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule